// File: doc/BRIEF.md
# DMA Channel Run and Completion Control

This block is the control and status logic of a single DMA channel. Software reaches it over a small register bus with separate read and write strobes. Through that bus it can set a channel enable, an interrupt enable and a pacing mode in a channel control word. It can set a master enable in a global word, and it loads a unit count. The block gates transfers on every enable and every error flag. It issues one transfer strobe per unit, waits for an acknowledge that stands in for the finished move, and decrements the count. It raises a completion flag when the count runs out.

Three sticky flags stop the channel: completion, NMI and address error. Software clears each of them with the same two-step handshake: it first reads the word while the flag shows 1, and then writes 0 to that bit. An NMI edge, an address error or clearing either enable stops the channel without raising completion. This lets software tell a finished run from an aborted one.

Top module: `dma_chan_ctl`

## Requirements
- R1: A transfer strobe is issued only while channel enable and master enable are both 1, the completion, NMI and address-error flags are all 0, and the count is nonzero.
- R2: Mode bit (control word bit 3) 0 paces transfers automatically: the strobe rises one cycle after the run condition holds. With bit 3 set to 1, each transfer needs `dreq` sampled high while the channel is idle and able to run.
- R3: Each `ack` while a unit is outstanding decrements the count by one. The ack that brings the count from 1 to 0 sets the completion flag (control word bit 1).
- R4: A rising `nmiIn` sets the NMI flag (global bit 1), and a high `addrErrIn` sets the address-error flag (global bit 2). Either one stops the outstanding unit without decrementing the count and leaves completion at 0.
- R5: Clearing channel enable (control bit 0) or master enable (global bit 0) ends the outstanding unit. The count is not decremented and completion stays 0.
- R6: A flag clears only when 0 is written to its bit after a read of the word returned it as 1. A write of 0 without that read, or a write of 1, leaves it set.
- R7: While the completion flag is 1, writing channel enable to 1 starts no transfer.
- R8: A count of 0 (address 2) starts no transfer.
- R9: The NMI flag is set by an edge and not by a level: once cleared, it stays 0 while `nmiIn` stays high.
- R10: `irq` is 1 exactly while the completion flag and the interrupt enable (control bit 2) are both 1.
- R11: After reset, all register words read 0, and `xferStrobe` and `irq` are 0. Address 0 is the control word, address 1 the global word and address 2 the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low asynchronous reset |
| regAddr | input | 2 | register select: 0 control, 1 global, 2 count |
| wrEn | input | 1 | write strobe |
| rdEn | input | 1 | read strobe; arms flag clearing |
| wrData | input | 16 | write data |
| rdData | output | 16 | read data for `regAddr`, combinational |
| nmiIn | input | 1 | non-maskable interrupt, edge sensitive |
| addrErrIn | input | 1 | address error report, level sensitive |
| dreq | input | 1 | transfer request in request-paced mode |
| ack | input | 1 | outstanding unit has been moved |
| xferStrobe | output | 1 | one-cycle pulse per unit to move |
| irq | output | 1 | completion interrupt |

## Verification
`rdData` follows `regAddr` in the same cycle. Register writes, flag sets and count updates take effect at the clock edge that samples the strobe, so the bench reads them back on the next cycle. `xferStrobe` rises one cycle after the edge where the run condition holds, and an abort clears the outstanding unit one edge after the run condition drops. The bench drives every input on falling edges and counts strobes on falling edges. It checks only after the one or two edges each result needs, and it waits extra idle cycles before each check so that a slower-than-required result still fails.

// File: rtl/dmactl_pkg.sv
package dmactl_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_GLOB = 2'd1;
  localparam logic [ADDR_W-1:0] A_CNT  = 2'd2;

  localparam int B_EN   = 0;
  localparam int B_DONE = 1;
  localparam int B_IE   = 2;
  localparam int B_REQ  = 3;
  localparam int B_MST  = 0;
  localparam int B_NMI  = 1;
  localparam int B_AE   = 2;

  localparam int NUM_FLAGS = 3;
  localparam int F_DONE = 0;
  localparam int F_NMI  = 1;
  localparam int F_AE   = 2;

  typedef struct packed {
    logic decr;
    logic finish;
  } ctlStrb_t;
endpackage

// File: rtl/dmactl_dpath.sv
module dmactl_dpath
  import dmactl_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              nmiIn,
  input  logic              addrErrIn,
  input  ctlStrb_t          strb,
  output logic              runOk,
  output logic              cntZero,
  output logic              cntOne,
  output logic              reqMode,
  output logic              irq
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic enQ, ieQ, reqQ, mstQ, nmiPrev;
  logic [CNT_W-1:0] cntQ;
  logic [NUM_FLAGS-1:0] flagQ, armQ, setVec, rdHit, wrHit, wrBit;

  wire wrCtrl = wrEn && regAddr == A_CTRL;
  wire wrGlob = wrEn && regAddr == A_GLOB;
  wire wrCnt  = wrEn && regAddr == A_CNT;

  always_comb begin
    setVec[F_DONE] = strb.finish;
    setVec[F_NMI]  = nmiIn && !nmiPrev;
    setVec[F_AE]   = addrErrIn;
    rdHit[F_DONE]  = rdEn && regAddr == A_CTRL;
    rdHit[F_NMI]   = rdEn && regAddr == A_GLOB;
    rdHit[F_AE]    = rdEn && regAddr == A_GLOB;
    wrHit[F_DONE]  = wrCtrl;
    wrHit[F_NMI]   = wrGlob;
    wrHit[F_AE]    = wrGlob;
    wrBit[F_DONE]  = wrData[B_DONE];
    wrBit[F_NMI]   = wrData[B_NMI];
    wrBit[F_AE]    = wrData[B_AE];
  end

  // sticky flags with read-one-then-write-zero clearing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= '0;
      armQ  <= '0;
    end else begin
      for (int i = 0; i < NUM_FLAGS; i++) begin
        if (setVec[i]) begin
          flagQ[i] <= 1'b1;
          armQ[i]  <= 1'b0;
        end else if (flagQ[i] && armQ[i] && wrHit[i] && !wrBit[i]) begin
          flagQ[i] <= 1'b0;
          armQ[i]  <= 1'b0;
        end else if (flagQ[i] && rdHit[i]) begin
          armQ[i] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ <= 1'b0; ieQ <= 1'b0; reqQ <= 1'b0; mstQ <= 1'b0;
      nmiPrev <= 1'b0;
      cntQ <= '0;
    end else begin
      nmiPrev <= nmiIn;
      if (wrCtrl) begin
        enQ  <= wrData[B_EN];
        ieQ  <= wrData[B_IE];
        reqQ <= wrData[B_REQ];
      end
      if (wrGlob) mstQ <= wrData[B_MST];
      if (wrCnt) cntQ <= wrData[CNT_W-1:0];
      else if (strb.decr) cntQ <= cntQ - CNT_ONE;
    end
  end

  always_comb begin
    rdData = '0;
    case (regAddr)
      A_CTRL: begin
        rdData[B_EN]   = enQ;
        rdData[B_DONE] = flagQ[F_DONE];
        rdData[B_IE]   = ieQ;
        rdData[B_REQ]  = reqQ;
      end
      A_GLOB: begin
        rdData[B_MST] = mstQ;
        rdData[B_NMI] = flagQ[F_NMI];
        rdData[B_AE]  = flagQ[F_AE];
      end
      A_CNT:   rdData = DATA_W'(cntQ);
      default: rdData = '0;
    endcase
  end

  assign runOk   = enQ && mstQ && (flagQ == '0);
  assign cntZero = cntQ == '0;
  assign cntOne  = cntQ == CNT_ONE;
  assign reqMode = reqQ;
  assign irq     = flagQ[F_DONE] && ieQ;

  p_done_at_last_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagQ[F_DONE]) |-> $past(cntQ) == CNT_ONE);
  p_done_clear_armed_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flagQ[F_DONE]) |-> $past(wrCtrl && !wrData[B_DONE] && armQ[F_DONE]));
  p_nmi_edge_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagQ[F_NMI]) |-> $past(nmiIn && !nmiPrev));
  p_no_flag_drop_on_one_r6: assert property (@(posedge clk) disable iff (!rstN)
    $past(wrHit[F_AE] && wrBit[F_AE]) && $past(flagQ[F_AE]) |-> flagQ[F_AE]);
endmodule

// File: rtl/dmactl_ctrl.sv
module dmactl_ctrl
  import dmactl_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     runOk,
  input  logic     cntZero,
  input  logic     cntOne,
  input  logic     reqMode,
  input  logic     dreq,
  input  logic     ack,
  output ctlStrb_t strb,
  output logic     xferStrobe
);
  logic busyQ, strobeQ;

  wire canStart = !busyQ && runOk && !cntZero && (!reqMode || dreq);
  wire unitDone = busyQ && runOk && ack;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      strobeQ <= 1'b0;
    end else begin
      strobeQ <= canStart;
      if (canStart) busyQ <= 1'b1;
      else if (busyQ && (!runOk || ack)) busyQ <= 1'b0;
    end
  end

  assign strb.decr   = unitDone;
  assign strb.finish = unitDone && cntOne;
  assign xferStrobe  = strobeQ;

  p_strobe_gated_r1: assert property (@(posedge clk) disable iff (!rstN)
    xferStrobe |-> $past(runOk && !cntZero));
  p_req_paced_r2: assert property (@(posedge clk) disable iff (!rstN)
    xferStrobe |-> $past(!reqMode || dreq));
  p_abort_drops_r5: assert property (@(posedge clk) disable iff (!rstN)
    busyQ && !runOk |=> !busyQ && !xferStrobe);
  p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    xferStrobe |=> !xferStrobe);
endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
  import dmactl_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              nmiIn,
  input  logic              addrErrIn,
  input  logic              dreq,
  input  logic              ack,
  output logic              xferStrobe,
  output logic              irq
);
  ctlStrb_t strb;
  logic runOk, cntZero, cntOne, reqMode;

  dmactl_dpath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .nmiIn(nmiIn), .addrErrIn(addrErrIn),
    .strb(strb), .runOk(runOk), .cntZero(cntZero), .cntOne(cntOne),
    .reqMode(reqMode), .irq(irq)
  );

  dmactl_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .runOk(runOk), .cntZero(cntZero), .cntOne(cntOne),
    .reqMode(reqMode), .dreq(dreq), .ack(ack), .strb(strb),
    .xferStrobe(xferStrobe)
  );
endmodule

// File: tb/tb_dma_chan_ctl.sv
module tb_dma_chan_ctl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic [1:0] regAddr = '0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [15:0] wrData = '0, rdData;
  logic nmiIn = 1'b0, addrErrIn = 1'b0, dreq = 1'b0, ack;
  logic xferStrobe, irq;
  int ackMode = 0;
  int nStrobe = 0;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_ctl dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .nmiIn(nmiIn), .addrErrIn(addrErrIn),
    .dreq(dreq), .ack(ack), .xferStrobe(xferStrobe), .irq(irq)
  );

  initial ack = 1'b0;
  always @(negedge clk) begin
    if (xferStrobe) nStrobe++;
    ack <= (ackMode == 1) ? 1'b1 : (ackMode == 2) ? 1'($urandom % 2) : 1'b0;
  end

  function automatic logic [15:0] expCtrl(bit en, bit done, bit ie, bit rq);
    return {12'd0, rq, ie, done, en};
  endfunction
  function automatic logic [15:0] expGlob(bit m, bit n, bit a);
    return {13'd0, a, n, m};
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wrReg(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    regAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdReg(logic [1:0] a, output logic [15:0] v);
    @(negedge clk);
    regAddr = a; rdEn = 1'b1;
    #1 v = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic pulseReq();
    @(negedge clk); dreq = 1'b1;
    @(negedge clk); dreq = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int s0;
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R11 reset state
    rdReg(0, v); check("R11 ctrl", v, 16'h0);
    rdReg(1, v); check("R11 glob", v, 16'h0);
    rdReg(2, v); check("R11 count", v, 16'h0);
    check("R11 strobe", 16'(xferStrobe), 16'h0);
    check("R11 irq", 16'(irq), 16'h0);

    // R8 zero count starts nothing
    wrReg(1, expGlob(1, 0, 0));
    wrReg(0, expCtrl(1, 0, 1, 0));
    idle(6);
    check("R8 zero count strobes", 16'(nStrobe), 16'd0);

    // R2 auto pacing, R3 count down and completion, R10 irq
    wrReg(0, 16'h0);
    wrReg(2, 16'd3);
    wrReg(0, expCtrl(1, 0, 1, 0));
    idle(4);
    check("R2 auto one strobe outstanding", 16'(nStrobe), 16'd1);
    rdReg(2, v); check("R3 no ack no decrement", v, 16'd3);
    ackMode = 1;
    idle(20);
    check("R3 strobes equal count", 16'(nStrobe), 16'd3);
    rdReg(2, v); check("R3 count reaches zero", v, 16'd0);
    rdReg(1, v); check("R3 glob unchanged", v, expGlob(1, 0, 0));
    check("R10 irq on completion", 16'(irq), 16'd1);

    // R6 flag clear rule and R7 blocked enable
    wrReg(2, 16'd2);
    wrReg(0, expCtrl(0, 0, 1, 0));
    wrReg(0, expCtrl(1, 0, 1, 0));
    idle(6);
    check("R7 enable while done no strobe", 16'(nStrobe), 16'd3);
    @(negedge clk); regAddr = 2'd0; #1;
    check("R6 done kept by unarmed write 0", rdData, expCtrl(1, 1, 1, 0));
    wrReg(0, expCtrl(1, 1, 0, 0));
    idle(1);
    check("R10 irq masked by ie=0", 16'(irq), 16'd0);
    @(negedge clk); regAddr = 2'd0; #1;
    check("R6 done kept by write 1", rdData, expCtrl(1, 1, 0, 0));
    rdReg(0, v);
    wrReg(0, expCtrl(1, 0, 1, 0));
    idle(1);
    check("R10 irq cleared with flag", 16'(irq), 16'd0);
    idle(12);
    check("R7 run resumes after clear", 16'(nStrobe), 16'd5);

    // R2 request pacing
    wrReg(2, 16'd2);
    rdReg(0, v);
    wrReg(0, expCtrl(1, 0, 0, 1));
    idle(6);
    check("R2 request mode waits for dreq", 16'(nStrobe), 16'd5);
    pulseReq();
    idle(4);
    check("R2 one strobe per dreq", 16'(nStrobe), 16'd6);
    rdReg(2, v); check("R2 count after one request", v, 16'd1);
    pulseReq();
    idle(4);
    rdReg(0, v); check("R2 done after second request", v, expCtrl(1, 1, 0, 1));

    // R4 NMI abort, R9 edge sensitivity
    ackMode = 0;
    wrReg(2, 16'd5);
    rdReg(0, v);
    wrReg(0, expCtrl(1, 0, 0, 0));
    idle(3);
    s0 = nStrobe;
    @(negedge clk); nmiIn = 1'b1;
    idle(2);
    ackMode = 1;
    idle(6);
    check("R4 nmi stops strobes", 16'(nStrobe), 16'(s0));
    rdReg(2, v); check("R4 nmi no decrement", v, 16'd5);
    rdReg(0, v); check("R4 nmi leaves done 0", v, expCtrl(1, 0, 0, 0));
    rdReg(1, v); check("R4 nmi flag set", v, expGlob(1, 1, 0));
    wrReg(1, expGlob(1, 0, 0));
    @(negedge clk); regAddr = 2'd1; #1;
    check("R9 nmi stays cleared with level high", rdData, expGlob(1, 0, 0));
    idle(20);
    rdReg(2, v); check("R4 run resumes from kept count", v, 16'd0);
    nmiIn = 1'b0;

    // R4 address error abort, R6 unarmed clear ignored
    ackMode = 0;
    wrReg(2, 16'd4);
    rdReg(0, v);
    wrReg(0, expCtrl(1, 0, 0, 0));
    idle(3);
    @(negedge clk); addrErrIn = 1'b1;
    @(negedge clk); addrErrIn = 1'b0;
    ackMode = 1;
    idle(6);
    rdReg(2, v); check("R4 addr error no decrement", v, 16'd4);
    rdReg(0, v); check("R4 addr error leaves done 0", v, expCtrl(1, 0, 0, 0));
    wrReg(0, expCtrl(0, 0, 0, 0));
    wrReg(1, expGlob(1, 0, 0));
    @(negedge clk); regAddr = 2'd1; #1;
    check("R6 addr error kept without read", rdData, expGlob(1, 0, 1));
    rdReg(1, v);
    wrReg(1, expGlob(1, 0, 0));
    @(negedge clk); regAddr = 2'd1; #1;
    check("R6 addr error cleared after read", rdData, expGlob(1, 0, 0));

    // R5 software aborts
    ackMode = 0;
    s0 = nStrobe;
    wrReg(0, expCtrl(1, 0, 0, 0));
    idle(2);
    wrReg(0, expCtrl(0, 0, 0, 0));
    ackMode = 1;
    idle(5);
    rdReg(2, v); check("R5 channel disable no decrement", v, 16'd4);
    ackMode = 0;
    wrReg(0, expCtrl(1, 0, 0, 0));
    idle(2);
    wrReg(1, expGlob(0, 0, 0));
    ackMode = 1;
    idle(5);
    rdReg(2, v); check("R5 master disable no decrement", v, 16'd4);
    rdReg(0, v); check("R5 done stays 0", v, expCtrl(1, 0, 0, 0));
    check("R1 two strobes for two starts", 16'(nStrobe - s0), 16'd2);
    wrReg(0, 16'h0);
    wrReg(1, expGlob(1, 0, 0));

    // random runs
    for (int it = 0; it < 20; it++) begin
      int n;
      bit rq;
      n = 1 + int'($urandom % 6);
      rq = 1'($urandom % 2);
      ackMode = 2;
      wrReg(2, 16'(n));
      s0 = nStrobe;
      wrReg(0, expCtrl(1, 0, 0, rq));
      if (rq) begin
        repeat (3 * n + 6) begin
          pulseReq();
          idle(int'($urandom % 3));
        end
      end else begin
        idle(8 * n + 20);
      end
      idle(10);
      check("R1 random strobe count", 16'(nStrobe - s0), 16'(n));
      rdReg(2, v); check("R3 random count zero", v, 16'd0);
      rdReg(0, v); check("R3 random done", v, expCtrl(1, 1, 0, rq));
      wrReg(0, expCtrl(0, 0, 0, 0));
      @(negedge clk); regAddr = 2'd0; #1;
      check("R6 random cleared", rdData, 16'h0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule